// File: doc/BRIEF.md
# Eight-Bit Accumulator Arithmetic/Logic Unit

This block is the data-path calculator of a small accumulator-style controller core. Each cycle it receives an operation code, the accumulator value, a second operand and the three incoming status flags (carry, auxiliary carry, overflow). It returns a new accumulator byte, a second byte meant for the companion B register, and the three updated flags. The result is captured in output registers, so it appears one clock edge after its inputs.

Operations cover binary addition with or without carry, subtraction with borrow, increment, decrement, decimal correction after packed-BCD addition, unsigned compare, an 8x8 multiply and an 8/8 divide that each split their answer across two bytes, the bitwise operations, complement, four rotates (plain and through carry) and a nibble exchange. Flags that an operation does not define are passed through from the inputs unchanged, so the surrounding core can write the flag outputs back to its status word every cycle without any decode of its own.

Top module: `alu8_core`

## Requirements
- R1: While `rst` is high at a rising clock edge, all outputs (`res_a`, `res_b`, `cy_out`, `ac_out`, `ov_out`) become zero at that edge.
- R2: Outputs are registered: a result appears at the first rising edge after its inputs and holds until the next edge. Unused codes 18 to 31 give `res_a` = `opa`, `res_b` = 0 and all flags copied from the inputs.
- R3: Code 0 (add) and code 1 (add with carry, adds `cy_in` as well) give the 8-bit sum; `cy_out` is the carry out of bit 7, `ac_out` the carry out of bit 3, `ov_out` the two's-complement overflow.
- R4: Code 2 (subtract with borrow) gives `opa - opb - cy_in`; `cy_out` is set on a borrow out of bit 7, `ac_out` on a borrow into bit 4, `ov_out` on two's-complement overflow.
- R5: Code 6 (compare) sets `cy_out` exactly when `opa < opb` unsigned, returns `res_a` = `opa`, and copies `ac_in` and `ov_in`.
- R6: Code 3 (increment) and code 4 (decrement) give `opa + 1` and `opa - 1` modulo 256, with all three flags copied from the inputs.
- R7: Code 5 (decimal adjust) adds 0x06 when the low nibble of `opa` exceeds 9 or `ac_in` is set, then adds 0x60 when the high nibble of that value exceeds 9, `cy_in` is set or the first step carried; `cy_out` is `cy_in` OR a carry out of bit 7 in either step; `ac_in`/`ov_in` are copied.
- R8: Code 7 (multiply) returns the product's low byte on `res_a` and high byte on `res_b`; `ov_out` is set when the product exceeds 255; `cy_out` is 0; `ac_in` is copied.
- R9: Code 8 (divide) returns quotient on `res_a` and remainder on `res_b` with `ov_out` = 0 for a nonzero divisor; a zero `opb` sets `ov_out` and leaves both result bytes undefined; `cy_out` is 0 in both cases and `ac_in` is copied.
- R10: Codes 9, 10, 11 and 12 give `opa & opb`, `opa | opb`, `opa ^ opb` and `~opa`, with all flags copied from the inputs.
- R11: Code 13 rotates `opa` left and code 15 rotates it right, flags copied; code 14 rotates left through carry (bit 0 takes `cy_in`, `cy_out` takes bit 7) and code 16 right through carry (bit 7 takes `cy_in`, `cy_out` takes bit 0), with `ac_in`/`ov_in` copied.
- R12: Code 17 exchanges the two nibbles of `opa` (bits 7:4 move to 3:0 and back), flags copied.
- R13: For every code other than 7 and 8, `res_b` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| op_sel | input | 5 | Operation code (0 to 17 defined) |
| opa | input | 8 | Accumulator operand |
| opb | input | 8 | Second operand |
| cy_in | input | 1 | Incoming carry flag |
| ac_in | input | 1 | Incoming auxiliary-carry flag |
| ov_in | input | 1 | Incoming overflow flag |
| res_a | output | 8 | Accumulator result (low product byte, quotient) |
| res_b | output | 8 | B-register result (high product byte, remainder) |
| cy_out | output | 1 | Resulting carry flag |
| ac_out | output | 1 | Resulting auxiliary-carry flag |
| ov_out | output | 1 | Resulting overflow flag |

## Verification
Every result of this unit, including the two-byte multiply and divide answers and all three flags, is due exactly one rising edge after the inputs that produce it. The bench changes inputs on a falling edge and reads the outputs on the following falling edge, so exactly one capturing edge lies between stimulus and sample; one scenario also reads the outputs just after a new input is applied to show they still hold the previous answer. Under reset the outputs are read after several edges with nonzero inputs present, and for a zero divisor only the flags are compared since the bytes are undefined.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  localparam int OP_W = 5;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 5'd0,
    OP_ADDC = 5'd1,
    OP_SUBB = 5'd2,
    OP_INC  = 5'd3,
    OP_DEC  = 5'd4,
    OP_DA   = 5'd5,
    OP_CMP  = 5'd6,
    OP_MUL  = 5'd7,
    OP_DIV  = 5'd8,
    OP_AND  = 5'd9,
    OP_OR   = 5'd10,
    OP_XOR  = 5'd11,
    OP_CPL  = 5'd12,
    OP_RL   = 5'd13,
    OP_RLC  = 5'd14,
    OP_RR   = 5'd15,
    OP_RRC  = 5'd16,
    OP_SWAP = 5'd17
  } alu_op_e;

  typedef struct packed {
    logic cy;
    logic ac;
    logic ov;
  } alu_flags_t;

endpackage

// File: rtl/alu8_arith.sv
module alu8_arith #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cy_in,
  input  logic         add_use_cy,
  output logic [W-1:0] add_r,
  output logic         add_cy,
  output logic         add_ac,
  output logic         add_ov,
  output logic [W-1:0] sub_r,
  output logic         sub_cy,
  output logic         sub_ac,
  output logic         sub_ov,
  output logic         lt,
  output logic [W-1:0] inc_r,
  output logic [W-1:0] dec_r
);
  localparam int NIB = W / 2;

  logic         add_cin;
  logic [W:0]   add_full;
  logic [NIB:0] add_low;
  logic [W:0]   sub_full;
  logic [NIB:0] sub_low;

  assign add_cin  = add_use_cy & cy_in;
  assign add_full = {1'b0, a} + {1'b0, b} + (W+1)'(add_cin);
  assign add_low  = {1'b0, a[NIB-1:0]} + {1'b0, b[NIB-1:0]} + (NIB+1)'(add_cin);
  assign add_r    = add_full[W-1:0];
  assign add_cy   = add_full[W];
  assign add_ac   = add_low[NIB];
  assign add_ov   = (a[W-1] == b[W-1]) && (add_full[W-1] != a[W-1]);

  assign sub_full = {1'b0, a} - {1'b0, b} - (W+1)'(cy_in);
  assign sub_low  = {1'b0, a[NIB-1:0]} - {1'b0, b[NIB-1:0]} - (NIB+1)'(cy_in);
  assign sub_r    = sub_full[W-1:0];
  assign sub_cy   = sub_full[W];
  assign sub_ac   = sub_low[NIB];
  assign sub_ov   = (a[W-1] != b[W-1]) && (sub_full[W-1] != a[W-1]);

  assign lt    = (a < b);
  assign inc_r = a + W'(1);
  assign dec_r = a - W'(1);

endmodule

// File: rtl/alu8_decadj.sv
module alu8_decadj #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic         cy_in,
  input  logic         ac_in,
  output logic [W-1:0] r,
  output logic         cy_out
);
  localparam int NIB = W / 2;
  localparam logic [W:0] ADJ_LO = (W+1)'(6);
  localparam logic [W:0] ADJ_HI = (W+1)'(6) << NIB;

  logic         fix_lo;
  logic         fix_hi;
  logic [W:0]   step1;
  logic [W:0]   step2;

  assign fix_lo = (a[NIB-1:0] > NIB'(9)) || ac_in;
  assign step1  = fix_lo ? ({1'b0, a} + ADJ_LO) : {1'b0, a};
  assign fix_hi = (step1[W-1:NIB] > (W-NIB)'(9)) || cy_in || step1[W];
  assign step2  = fix_hi ? ({1'b0, step1[W-1:0]} + ADJ_HI) : {1'b0, step1[W-1:0]};
  assign r      = step2[W-1:0];
  assign cy_out = cy_in | step1[W] | step2[W];

endmodule

// File: rtl/alu8_muldiv.sv
module alu8_muldiv #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] prod_lo,
  output logic [W-1:0] prod_hi,
  output logic [W-1:0] quot,
  output logic [W-1:0] rem,
  output logic         div_zero
);
  localparam int PW = 2 * W;

  logic [PW-1:0] prod;

  assign prod    = PW'(a) * PW'(b);
  assign prod_lo = prod[W-1:0];
  assign prod_hi = prod[PW-1:W];

  assign div_zero = (b == '0);

  always_comb begin
    if (div_zero) begin
      quot = '1;
      rem  = a;
    end else begin
      quot = a / b;
      rem  = a % b;
    end
  end

endmodule

// File: rtl/alu8_bitops.sv
module alu8_bitops #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cy_in,
  output logic [W-1:0] and_r,
  output logic [W-1:0] or_r,
  output logic [W-1:0] xor_r,
  output logic [W-1:0] cpl_r,
  output logic [W-1:0] rl_r,
  output logic [W-1:0] rr_r,
  output logic [W-1:0] rlc_r,
  output logic         rlc_cy,
  output logic [W-1:0] rrc_r,
  output logic         rrc_cy,
  output logic [W-1:0] swap_r
);
  localparam int NIB = W / 2;

  assign and_r = a & b;
  assign or_r  = a | b;
  assign xor_r = a ^ b;
  assign cpl_r = ~a;

  assign rl_r   = {a[W-2:0], a[W-1]};
  assign rr_r   = {a[0], a[W-1:1]};
  assign rlc_r  = {a[W-2:0], cy_in};
  assign rlc_cy = a[W-1];
  assign rrc_r  = {cy_in, a[W-1:1]};
  assign rrc_cy = a[0];

  assign swap_r = {a[NIB-1:0], a[W-1:NIB]};

endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [OP_W-1:0] op_sel,
  input  logic [W-1:0]    opa,
  input  logic [W-1:0]    opb,
  input  logic            cy_in,
  input  logic            ac_in,
  input  logic            ov_in,
  output logic [W-1:0]    res_a,
  output logic [W-1:0]    res_b,
  output logic            cy_out,
  output logic            ac_out,
  output logic            ov_out
);

  logic [W-1:0] add_r, sub_r, inc_r, dec_r;
  logic         add_cy, add_ac, add_ov;
  logic         sub_cy, sub_ac, sub_ov, lt;
  logic [W-1:0] da_r;
  logic         da_cy;
  logic [W-1:0] prod_lo, prod_hi, quot, rem;
  logic         div_zero;
  logic [W-1:0] and_r, or_r, xor_r, cpl_r, rl_r, rr_r, rlc_r, rrc_r, swap_r;
  logic         rlc_cy, rrc_cy;

  logic [W-1:0] nx_a, nx_b;
  alu_flags_t   nx_f, fl_in;

  assign fl_in = '{cy: cy_in, ac: ac_in, ov: ov_in};

  alu8_arith #(.W(W)) u_arith (
    .a(opa), .b(opb), .cy_in(cy_in), .add_use_cy(op_sel == OP_ADDC),
    .add_r(add_r), .add_cy(add_cy), .add_ac(add_ac), .add_ov(add_ov),
    .sub_r(sub_r), .sub_cy(sub_cy), .sub_ac(sub_ac), .sub_ov(sub_ov),
    .lt(lt), .inc_r(inc_r), .dec_r(dec_r)
  );

  alu8_decadj #(.W(W)) u_decadj (
    .a(opa), .cy_in(cy_in), .ac_in(ac_in), .r(da_r), .cy_out(da_cy)
  );

  alu8_muldiv #(.W(W)) u_muldiv (
    .a(opa), .b(opb), .prod_lo(prod_lo), .prod_hi(prod_hi),
    .quot(quot), .rem(rem), .div_zero(div_zero)
  );

  alu8_bitops #(.W(W)) u_bitops (
    .a(opa), .b(opb), .cy_in(cy_in),
    .and_r(and_r), .or_r(or_r), .xor_r(xor_r), .cpl_r(cpl_r),
    .rl_r(rl_r), .rr_r(rr_r), .rlc_r(rlc_r), .rlc_cy(rlc_cy),
    .rrc_r(rrc_r), .rrc_cy(rrc_cy), .swap_r(swap_r)
  );

  always_comb begin
    nx_a = opa;
    nx_b = '0;
    nx_f = fl_in;
    case (op_sel)
      OP_ADD, OP_ADDC: begin
        nx_a = add_r;
        nx_f = '{cy: add_cy, ac: add_ac, ov: add_ov};
      end
      OP_SUBB: begin
        nx_a = sub_r;
        nx_f = '{cy: sub_cy, ac: sub_ac, ov: sub_ov};
      end
      OP_INC:  nx_a = inc_r;
      OP_DEC:  nx_a = dec_r;
      OP_DA: begin
        nx_a    = da_r;
        nx_f.cy = da_cy;
      end
      OP_CMP:  nx_f.cy = lt;
      OP_MUL: begin
        nx_a    = prod_lo;
        nx_b    = prod_hi;
        nx_f.cy = 1'b0;
        nx_f.ov = (prod_hi != '0);
      end
      OP_DIV: begin
        nx_a    = quot;
        nx_b    = rem;
        nx_f.cy = 1'b0;
        nx_f.ov = div_zero;
      end
      OP_AND:  nx_a = and_r;
      OP_OR:   nx_a = or_r;
      OP_XOR:  nx_a = xor_r;
      OP_CPL:  nx_a = cpl_r;
      OP_RL:   nx_a = rl_r;
      OP_RR:   nx_a = rr_r;
      OP_RLC: begin
        nx_a    = rlc_r;
        nx_f.cy = rlc_cy;
      end
      OP_RRC: begin
        nx_a    = rrc_r;
        nx_f.cy = rrc_cy;
      end
      OP_SWAP: nx_a = swap_r;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_a  <= '0;
      res_b  <= '0;
      cy_out <= 1'b0;
      ac_out <= 1'b0;
      ov_out <= 1'b0;
    end else begin
      res_a  <= nx_a;
      res_b  <= nx_b;
      cy_out <= nx_f.cy;
      ac_out <= nx_f.ac;
      ov_out <= nx_f.ov;
    end
  end

endmodule

// File: rtl/alu8_chk.sv
module alu8_chk
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input logic            clk,
  input logic            rst,
  input logic [OP_W-1:0] op_sel,
  input logic [W-1:0]    opa,
  input logic [W-1:0]    opb,
  input logic            cy_in,
  input logic            ac_in,
  input logic            ov_in,
  input logic [W-1:0]    res_a,
  input logic [W-1:0]    res_b,
  input logic            cy_out,
  input logic            ac_out,
  input logic            ov_out
);
  localparam int NIB = W / 2;

  logic armed;

  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
  end

  AST_RST_CLEARS: assert property (@(posedge clk)
    rst |=> (res_a == '0 && res_b == '0 && !cy_out && !ac_out && !ov_out)); // R1

  AST_INCDEC_FLAGS: assert property (@(posedge clk) disable iff (rst)
    (armed && ($past(op_sel) == OP_INC || $past(op_sel) == OP_DEC)) |->
    (cy_out == $past(cy_in) && ac_out == $past(ac_in) && ov_out == $past(ov_in))); // R6

  AST_LOGIC_FLAGS: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(op_sel) inside {OP_AND, OP_OR, OP_XOR, OP_CPL}) |->
    (cy_out == $past(cy_in) && ac_out == $past(ac_in) && ov_out == $past(ov_in))); // R10

  AST_CMP_KEEPS_A: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(op_sel) == OP_CMP) |->
    (res_a == $past(opa) && ac_out == $past(ac_in) && ov_out == $past(ov_in))); // R5

  AST_DA_CY_STICKY: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(op_sel) == OP_DA && $past(cy_in)) |-> cy_out); // R7

  AST_MUL_FLAGS: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(op_sel) == OP_MUL) |-> (!cy_out && ov_out == (res_b != '0))); // R8

  AST_DIV_ZERO: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(op_sel) == OP_DIV && $past(opb) == '0) |-> (ov_out && !cy_out)); // R9

  AST_SWAP_NIBBLES: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(op_sel) == OP_SWAP) |->
    (res_a[W-1:NIB] == $past(opa[NIB-1:0]) && res_a[NIB-1:0] == $past(opa[W-1:NIB]))); // R12

  AST_B_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(op_sel) != OP_MUL && $past(op_sel) != OP_DIV) |-> (res_b == '0)); // R13

endmodule

bind alu8_core alu8_chk #(.W(W)) u_alu8_chk (.*);

// File: tb/test_alu8_core.sv
module test_alu8_core;
  import alu8_pkg::*;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [4:0] op_sel = '0;
  logic [7:0] opa = '0, opb = '0;
  logic       cy_in = 1'b0, ac_in = 1'b0, ov_in = 1'b0;
  logic [7:0] res_a, res_b;
  logic       cy_out, ac_out, ov_out;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  done  = 1'b0;
  logic [15:0] lf = 16'hACE1;

  always #10 clk = ~clk;

  alu8_core i_alu8_core (
    .clk(clk), .rst(rst), .op_sel(op_sel), .opa(opa), .opb(opb),
    .cy_in(cy_in), .ac_in(ac_in), .ov_in(ov_in),
    .res_a(res_a), .res_b(res_b), .cy_out(cy_out), .ac_out(ac_out), .ov_out(ov_out)
  );

  function automatic int sgn(input int v);
    return (v > 127) ? v - 256 : v;
  endfunction

  // Reference model written from the requirements using integer arithmetic.
  function automatic void model(input logic [4:0] op, input logic [7:0] a, input logic [7:0] b,
                                input logic ci, input logic ai, input logic oi,
                                output logic [7:0] ea, output logic [7:0] eb,
                                output logic ec, output logic eac, output logic eov);
    int ia, ib, c, t, st;
    ia = int'(a); ib = int'(b); c = ci ? 1 : 0;
    ea = a; eb = 8'h00; ec = ci; eac = ai; eov = oi;
    case (op)
      OP_ADD, OP_ADDC: begin
        if (op == OP_ADD) c = 0;
        t = ia + ib + c; st = sgn(ia) + sgn(ib) + c;
        ea = 8'(t); ec = (t > 255); eac = ((ia % 16) + (ib % 16) + c) > 15;
        eov = (st > 127) || (st < -128);
      end
      OP_SUBB: begin
        t = ia - ib - c; st = sgn(ia) - sgn(ib) - c;
        ea = 8'(t); ec = (t < 0); eac = ((ia % 16) - (ib % 16) - c) < 0;
        eov = (st > 127) || (st < -128);
      end
      OP_INC: ea = 8'((ia + 1) % 256);
      OP_DEC: ea = 8'((ia + 255) % 256);
      OP_DA: begin
        t = ia;
        if ((ia % 16) > 9 || ai) t = t + 6;
        if (((t / 16) % 16) > 9 || ci || t > 255) t = t + 96;
        ea = 8'(t % 256); ec = ci || (t > 255);
      end
      OP_CMP: ec = (ia < ib);
      OP_MUL: begin
        t = ia * ib; ea = 8'(t % 256); eb = 8'(t / 256); ec = 1'b0; eov = (t > 255);
      end
      OP_DIV: begin
        ec = 1'b0;
        if (ib == 0) eov = 1'b1;
        else begin eov = 1'b0; ea = 8'(ia / ib); eb = 8'(ia % ib); end
      end
      OP_AND:  ea = a & b;
      OP_OR:   ea = a | b;
      OP_XOR:  ea = a ^ b;
      OP_CPL:  ea = 8'(255 - ia);
      OP_RL:   ea = 8'(((ia * 2) % 256) + ia / 128);
      OP_RR:   ea = 8'(ia / 2 + (ia % 2) * 128);
      OP_RLC: begin ea = 8'(((ia * 2) % 256) + c); ec = (ia >= 128); end
      OP_RRC: begin ea = 8'(ia / 2 + c * 128); ec = (ia % 2) == 1; end
      OP_SWAP: ea = 8'((ia % 16) * 16 + ia / 16);
      default: ;
    endcase
  endfunction

  function automatic string req_of(input int op);
    case (op)
      0, 1: return "R3";
      2: return "R4";
      3, 4: return "R6";
      5: return "R7";
      6: return "R5";
      7: return "R8";
      8: return "R9";
      9, 10, 11, 12: return "R10";
      13, 14, 15, 16: return "R11";
      17: return "R12";
      default: return "R2";
    endcase
  endfunction

  task automatic compare(input string tag, input logic [4:0] op, input logic [7:0] a, input logic [7:0] b,
                         input logic [7:0] ea, input logic [7:0] eb,
                         input logic ec, input logic eac, input logic eov, input bit skip_bytes);
    n_chk++;
    if ((!skip_bytes && (res_a !== ea || res_b !== eb)) ||
        cy_out !== ec || ac_out !== eac || ov_out !== eov) begin
      n_bad++;
      $display("FAIL %s op=%0d a=%h b=%h: actual a=%h b=%h cy=%b ac=%b ov=%b expected a=%h b=%h cy=%b ac=%b ov=%b",
               tag, op, a, b, res_a, res_b, cy_out, ac_out, ov_out, ea, eb, ec, eac, eov);
    end
  endtask

  task automatic run(input string tag, input logic [4:0] op, input logic [7:0] a, input logic [7:0] b,
                     input logic ci, input logic ai, input logic oi);
    logic [7:0] ea, eb;
    logic ec, eac, eov;
    @(negedge clk);
    op_sel = op; opa = a; opb = b; cy_in = ci; ac_in = ai; ov_in = oi;
    model(op, a, b, ci, ai, oi, ea, eb, ec, eac, eov);
    @(negedge clk);
    compare(tag, op, a, b, ea, eb, ec, eac, eov, (op == OP_DIV) && (b == 8'h00));
  endtask

  task automatic t_reset;
    rst = 1'b1;
    op_sel = OP_MUL; opa = 8'hFF; opb = 8'hFF; cy_in = 1'b1; ac_in = 1'b1; ov_in = 1'b1;
    repeat (3) @(negedge clk);
    compare("R1 reset", OP_MUL, 8'hFF, 8'hFF, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0);
    rst = 1'b0;
  endtask

  task automatic t_latency;
    run("R2 prime", OP_ADD, 8'h01, 8'h01, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    op_sel = OP_ADD; opa = 8'h03; opb = 8'h04;
    #2;
    compare("R2 hold before edge", OP_ADD, 8'h03, 8'h04, 8'h02, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    compare("R2 after one edge", OP_ADD, 8'h03, 8'h04, 8'h07, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0);
    run("R2 unused code", 5'd25, 8'hA5, 8'h3C, 1'b1, 1'b0, 1'b1);
    run("R2 unused code", 5'd31, 8'h00, 8'hFF, 1'b0, 1'b1, 1'b0);
  endtask

  task automatic t_add;
    run("R3 signed ovf", OP_ADD, 8'h7F, 8'h01, 1'b0, 1'b0, 1'b0);
    run("R3 wrap", OP_ADD, 8'hFF, 8'h01, 1'b1, 1'b0, 1'b1);
    run("R3 addc half", OP_ADDC, 8'h0E, 8'h01, 1'b1, 1'b0, 1'b0);
    run("R3 neg ovf", OP_ADD, 8'h80, 8'h80, 1'b0, 1'b1, 1'b0);
  endtask

  task automatic t_sub;
    run("R4 borrow", OP_SUBB, 8'h00, 8'h01, 1'b0, 1'b0, 1'b0);
    run("R4 signed ovf", OP_SUBB, 8'h80, 8'h01, 1'b0, 1'b0, 1'b0);
    run("R4 borrow in", OP_SUBB, 8'h10, 8'h0F, 1'b1, 1'b0, 1'b1);
    run("R4 equal", OP_SUBB, 8'h5A, 8'h5A, 1'b0, 1'b1, 1'b1);
  endtask

  task automatic t_cmp_incdec;
    run("R5 less", OP_CMP, 8'h10, 8'h11, 1'b0, 1'b1, 1'b0);
    run("R5 equal", OP_CMP, 8'h42, 8'h42, 1'b1, 1'b0, 1'b1);
    run("R6 inc wrap", OP_INC, 8'hFF, 8'h00, 1'b1, 1'b1, 1'b0);
    run("R6 dec wrap", OP_DEC, 8'h00, 8'h00, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic t_da;
    run("R7 both nibbles", OP_DA, 8'h9A, 8'h00, 1'b0, 1'b0, 1'b0);
    run("R7 aux carry", OP_DA, 8'h11, 8'h00, 1'b0, 1'b1, 1'b0);
    run("R7 carry in", OP_DA, 8'h23, 8'h00, 1'b1, 1'b0, 1'b1);
    run("R7 first step carry", OP_DA, 8'hFA, 8'h00, 1'b0, 1'b0, 1'b0);
    run("R7 no change", OP_DA, 8'h45, 8'h00, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_muldiv;
    run("R8 exceeds byte", OP_MUL, 8'h10, 8'h10, 1'b1, 1'b0, 1'b0);
    run("R8 fits byte", OP_MUL, 8'h0F, 8'h11, 1'b1, 1'b1, 1'b1);
    run("R8 max", OP_MUL, 8'hFF, 8'hFF, 1'b0, 1'b0, 1'b0);
    run("R9 divide", OP_DIV, 8'hFF, 8'h10, 1'b1, 1'b0, 1'b1);
    run("R9 zero divisor", OP_DIV, 8'h05, 8'h00, 1'b1, 1'b1, 1'b0);
    run("R9 small", OP_DIV, 8'h03, 8'h07, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic t_bits;
    run("R10 and", OP_AND, 8'hF0, 8'h3C, 1'b1, 1'b0, 1'b1);
    run("R10 or", OP_OR, 8'hF0, 8'h0C, 1'b0, 1'b1, 1'b0);
    run("R10 xor", OP_XOR, 8'hAA, 8'hFF, 1'b1, 1'b1, 1'b1);
    run("R10 cpl", OP_CPL, 8'h5A, 8'h00, 1'b0, 1'b0, 1'b0);
    run("R11 rl", OP_RL, 8'h81, 8'h00, 1'b0, 1'b1, 1'b0);
    run("R11 rr", OP_RR, 8'h81, 8'h00, 1'b1, 1'b0, 1'b1);
    run("R11 rlc", OP_RLC, 8'h80, 8'h00, 1'b1, 1'b0, 1'b0);
    run("R11 rrc", OP_RRC, 8'h01, 8'h00, 1'b0, 1'b1, 1'b1);
    run("R12 swap", OP_SWAP, 8'h3C, 8'h00, 1'b1, 1'b0, 1'b1);
    run("R13 b zero after and", OP_AND, 8'hFF, 8'hFF, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_sweep;
    for (int op = 0; op < 20; op++) begin
      for (int k = 0; k < 150; k++) begin
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        run(req_of(op), 5'(op), lf[7:0], lf[15:8], lf[0] ^ lf[5], lf[3], lf[9]);
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired: actual not finished expected finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset;
    t_latency;
    t_add;
    t_sub;
    t_cmp_incdec;
    t_da;
    t_muldiv;
    t_bits;
    t_sweep;
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule